// File: doc/BRIEF.md
# Write-to-Clear-by-AND Interrupt Controller

This block gathers up to sixteen peripheral interrupt requests into one line to the CPU. It has two 16-bit registers on a simple register bus: a pending register and an enable register. While a request input is high, its pending bit is set. The bit stays set until software clears it. To clear a bit, software writes a word to the pending register, and the block ANDs that word into the pending bits. Each zero in the word clears the matching bit, and each one leaves it as it was. The enable register holds what software last wrote to it.

The CPU line is high whenever some bit is both pending and enabled. A separate one-cycle pulse goes out after an enable write that leaves at least one pending source unmasked. The processor side can use this pulse to check for interrupts at once, without waiting for its next poll. The block does not prioritise or vector interrupts.

Top module: `irqc_top`

## Requirements
- R1: After reset, both registers read zero and `cpu_irq` and `unmask_pulse` are low.
- R2: A read at byte offset 0x070 returns the pending register, and a read at 0x074 returns the enable register. Both sit in bits 15:0 of `bus_rdata` with bits 31:16 zero. Reads are combinational and change no state.
- R3: A read at any other offset returns zero.
- R4: A write at 0x074 loads `bus_wdata[15:0]` into the enable register on that clock edge.
- R5: A write at 0x070 replaces the pending register with (pending AND `bus_wdata[15:0]`). A zero bit clears, and a one bit neither clears nor sets.
- R6: A high `src_req[i]` at a clock edge sets pending bit i. The bit stays set after the request falls, until it is cleared by a write.
- R7: If a request and a clearing write reach the same bit in the same cycle, the bit stays set.
- R8: `cpu_irq` is high exactly when (pending AND enable) is nonzero in the registered state. The line therefore follows any register change in the cycle after the edge that made it.
- R9: After an enable write, `unmask_pulse` is high for exactly the next cycle if (pending before the edge AND written enable) is nonzero. Otherwise the pulse stays low, and it never rises without an enable write.
- R10: A write at any other offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data, bits 15:0 used |
| bus_rdata | output | 32 | Combinational read data |
| src_req | input | 16 | Level-sampled request per source |
| cpu_irq | output | 1 | Combined interrupt to the CPU |
| unmask_pulse | output | 1 | One-cycle pulse after an unmasking enable write |

## Verification
The bound checker watches several rules on every cycle:
- an enable write of zero silences `cpu_irq` on the following cycle;
- a request bit is always captured in the pending register;
- a clearing write with no request present leaves exactly the AND of the old pending bits and the written word;
- the enable register follows each enable write and holds through writes to other offsets;
- the pulse appears only after an enable write and always with `cpu_irq` high.

The bench scenarios cover what needs a chosen history:
- read-back at each offset and the zero extension;
- a bit that stays pending after its request falls;
- a request that beats a clear in the same cycle;
- enable writes that do and do not unmask a pending source.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_ENAB = 2'd2
  } irqc_sel_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] PEND_OFF = 'h070,
  parameter logic [ADDR_W-1:0] ENAB_OFF = 'h074
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output irqc_sel_e         sel,
  output logic              pend_we,
  output logic              enab_we
);
  always_comb begin
    if (addr == PEND_OFF)      sel = SEL_PEND;
    else if (addr == ENAB_OFF) sel = SEL_ENAB;
    else                       sel = SEL_NONE;
  end

  assign pend_we = we && (sel == SEL_PEND);
  assign enab_we = we && (sel == SEL_ENAB);
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_we,
  input  logic [SRC_W-1:0] clr_word,
  input  logic [SRC_W-1:0] set_req,
  output logic [SRC_W-1:0] pend_q
);
  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    logic kept;
    // A request wins over a clearing zero in the same cycle.
    assign kept = clr_we ? (pend_q[i] & clr_word[i]) : pend_q[i];
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= kept | set_req[i];
    end
  end
endmodule

// File: rtl/irqc_enable.sv
module irqc_enable #(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [SRC_W-1:0] ld_word,
  output logic [SRC_W-1:0] enab_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  enab_q <= '0;
    else if (ld) enab_q <= ld_word;
  end
endmodule

// File: rtl/irqc_readmux.sv
module irqc_readmux
  import irqc_pkg::*;
#(
  parameter int SRC_W  = 16,
  parameter int DATA_W = 32
) (
  input  irqc_sel_e         sel,
  input  logic [SRC_W-1:0]  pend,
  input  logic [SRC_W-1:0]  enab,
  output logic [DATA_W-1:0] rdata
);
  logic [SRC_W-1:0] picked;

  always_comb begin
    case (sel)
      SEL_PEND: picked = pend;
      SEL_ENAB: picked = enab;
      default:  picked = '0;
    endcase
  end

  if (DATA_W > SRC_W) begin : g_ext
    assign rdata = {{(DATA_W-SRC_W){1'b0}}, picked};
  end else begin : g_trunc
    assign rdata = picked[DATA_W-1:0];
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int SRC_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] PEND_OFF = 'h070,
  parameter logic [ADDR_W-1:0] ENAB_OFF = 'h074
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SRC_W-1:0]  src_req,
  output logic              cpu_irq,
  output logic              unmask_pulse
);
  irqc_sel_e        sel;
  logic             pend_we, enab_we;
  logic [SRC_W-1:0] pend_q, enab_q, wword;
  logic             pulse_q;

  assign wword = bus_wdata[SRC_W-1:0];

  irqc_decode #(.ADDR_W(ADDR_W), .PEND_OFF(PEND_OFF), .ENAB_OFF(ENAB_OFF)) u_dec (
    .addr(bus_addr), .we(bus_we), .sel(sel), .pend_we(pend_we), .enab_we(enab_we)
  );

  irqc_pending #(.SRC_W(SRC_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .clr_we(pend_we), .clr_word(wword),
    .set_req(src_req), .pend_q(pend_q)
  );

  irqc_enable #(.SRC_W(SRC_W)) u_enab (
    .clk(clk), .rst_n(rst_n), .ld(enab_we), .ld_word(wword), .enab_q(enab_q)
  );

  irqc_readmux #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_rd (
    .sel(sel), .pend(pend_q), .enab(enab_q), .rdata(bus_rdata)
  );

  assign cpu_irq = |(pend_q & enab_q);

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= enab_we && (|(pend_q & wword));
  end
  assign unmask_pulse = pulse_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int SRC_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] PEND_OFF = 'h070,
  parameter logic [ADDR_W-1:0] ENAB_OFF = 'h074
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [SRC_W-1:0]  src_req,
  input logic              cpu_irq,
  input logic              unmask_pulse,
  input logic [SRC_W-1:0]  pend_q,
  input logic [SRC_W-1:0]  enab_q
);
  logic wr_enab, wr_pend, wr_other;
  assign wr_enab  = bus_we && (bus_addr == ENAB_OFF);
  assign wr_pend  = bus_we && (bus_addr == PEND_OFF);
  assign wr_other = bus_we && !wr_enab && !wr_pend;

  assert_zero_enable_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_enab && bus_wdata[SRC_W-1:0] == '0) |=> !cpu_irq);

  assert_request_captured_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req != '0) |=> ((pend_q & $past(src_req)) == $past(src_req)));

  assert_and_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && src_req == '0) |=> (pend_q == ($past(pend_q) & $past(bus_wdata[SRC_W-1:0]))));

  assert_enable_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enab |=> (enab_q == $past(bus_wdata[SRC_W-1:0])));

  assert_other_write_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_other |=> $stable(enab_q));

  assert_pulse_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_pulse |-> $past(wr_enab));

  assert_pulse_with_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_pulse |-> cpu_irq);
endmodule

bind irqc_top irqc_checker #(
  .SRC_W(SRC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .PEND_OFF(PEND_OFF), .ENAB_OFF(ENAB_OFF)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .src_req(src_req), .cpu_irq(cpu_irq),
  .unmask_pulse(unmask_pulse), .pend_q(pend_q), .enab_q(enab_q)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb_top;
  localparam logic [11:0] PEND = 12'h070;
  localparam logic [11:0] ENAB = 12'h074;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] src_req = '0;
  logic        cpu_irq, unmask_pulse;

  always #2.5 clk = ~clk;

  irqc_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
    .cpu_irq(cpu_irq), .unmask_pulse(unmask_pulse)
  );

  // kind: 0 = read data at addr, 1 = cpu_irq, 2 = unmask_pulse
  typedef struct {
    int          kind;
    logic [11:0] addr;
    logic [31:0] exp;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  event sample_ev;

  // Monitor: pops one expectation per sample event and compares at the ports.
  initial begin
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        exp_t e;
        logic [31:0] act;
        e = q.pop_front();
        if (e.kind == 0) act = bus_rdata;
        else if (e.kind == 1) act = {31'b0, cpu_irq};
        else act = {31'b0, unmask_pulse};
        n_checks++;
        if (act !== e.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h",
                   e.req, e.kind, e.addr, act, e.exp);
        end
      end
    end
  end

  task automatic expect_item(input int kind, input logic [11:0] a,
                             input logic [31:0] v, input string req);
    exp_t e;
    if (kind == 0) bus_addr = a;
    e.kind = kind; e.addr = a; e.exp = v; e.req = req;
    q.push_back(e);
    #0.2;
    -> sample_ev;
    #0.2;
  endtask

  // Write: drive at a falling edge, finish at the next falling edge (registers updated).
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                           input logic [15:0] req_same);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d; src_req = req_same;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0; src_req = '0;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_item(0, PEND, 32'h0, "R1");
    expect_item(0, ENAB, 32'h0, "R1");
    expect_item(1, '0, 32'h0, "R1");
    expect_item(2, '0, 32'h0, "R1");

    // R6: one-cycle request on bits 0 and 2, stays pending after it falls
    src_req = 16'h0005;
    @(negedge clk);
    src_req = '0;
    @(negedge clk);
    expect_item(0, PEND, 32'h0000_0005, "R6");
    expect_item(1, '0, 32'h0, "R8");

    // R4/R9/R8: enabling bit 2 unmasks a pending source
    bus_write(ENAB, 32'h0000_0004, '0);
    expect_item(2, '0, 32'h1, "R9");
    expect_item(1, '0, 32'h1, "R8");
    expect_item(0, ENAB, 32'h0000_0004, "R4");
    idle_cycle();
    expect_item(2, '0, 32'h0, "R9");

    // R5: clear bit 2 only; ones do not set bit 4
    bus_write(PEND, 32'h0000_FFFB, '0);
    expect_item(0, PEND, 32'h0000_0001, "R5");
    expect_item(1, '0, 32'h0, "R8");

    // R9: enable write that unmasks nothing pending
    bus_write(ENAB, 32'h0000_0002, '0);
    expect_item(2, '0, 32'h0, "R9");
    expect_item(1, '0, 32'h0, "R8");

    // R7: request on bit 3 in the same cycle as a write clearing bit 3
    bus_write(PEND, 32'h0000_FFF7, 16'h0008);
    expect_item(0, PEND, 32'h0000_0009, "R7");

    // R3 and R10: other offsets read zero, writes there are inert
    expect_item(0, 12'h078, 32'h0, "R3");
    expect_item(0, 12'h000, 32'h0, "R3");
    bus_write(12'h078, 32'h0000_0000, '0);
    expect_item(0, PEND, 32'h0000_0009, "R10");
    expect_item(0, ENAB, 32'h0000_0002, "R10");

    // R2: upper written bits dropped, reads zero-extended
    bus_write(ENAB, 32'hFFFF_ABCD, '0);
    expect_item(0, ENAB, 32'h0000_ABCD, "R2");
    expect_item(2, '0, 32'h1, "R9");
    expect_item(1, '0, 32'h1, "R8");

    // R5/R8: clear everything
    bus_write(PEND, 32'h0000_0000, '0);
    expect_item(0, PEND, 32'h0, "R5");
    expect_item(1, '0, 32'h0, "R8");

    // R8: a request on an enabled bit raises the line the next cycle
    @(negedge clk);
    src_req = 16'h0100;
    @(negedge clk);
    src_req = '0;
    expect_item(1, '0, 32'h1, "R8");

    idle_cycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule